// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Array

This block is a two-level combinational logic array whose function is set entirely by configuration bits held in registers. Twelve dedicated inputs and ten bidirectional pins form twenty-two variables. Each variable reaches every product term in both its true and its inverted form. Thirty-two logic product terms feed ten OR gates through a programmable connection matrix. Each OR result then passes through a polarity stage that can invert it. Ten further product terms are control terms, and each one decides whether its own pin is driven.

A pin that is not driven behaves as an input: its external value goes into the product terms. A driven pin feeds back the value the array itself drives. The pin is split into three ports, one for the driven value, one for the enable and one for the sampled external value, so that an enclosing pad ring can build the three-state buffer.

The configuration is written one bit per clock through a shift port. During reset every link is restored to the connected state and every output is made active-high. In that state every product term is disabled but still connected to every OR gate.

Top module: `pla_array`

## Requirements
- R1: After reset, with no configuration loaded, every term is off: `pin_oe` is 0 and `pin_out` is 0 for any input values.
- R2: While `cfg_load` is 1, each rising clock edge shifts `cfg_din` into the configuration register. After a full load of CFG_BITS bits, the first bit sent lands at index 0. Index t*2*V+2*v is the true link of variable v on term t, and index t*2*V+2*v+1 is its inverted link, where V = N_IN+N_IO. Variables 0..N_IN-1 are `in_i`, and variables N_IN..V-1 are pins 0..N_IO-1. Terms 0..N_LT-1 are logic terms, and term N_LT+n is the control term of pin n. The OR links follow, at index AND_BITS+t*N_IO+o, and the polarity bits come last, at index AND_BITS+OR_BITS+o. A link bit of 1 means connected.
- R3: A term that has both the true and the inverted link of any one variable connected is 0, whatever the variable values.
- R4: A variable whose two links are both cut on a term does not affect that term. A term with every link cut is 1.
- R5: Output o is the OR of the logic terms whose OR link to o is connected. An unconnected term contributes 0.
- R6: A polarity bit of 1 inverts the OR result of its output. A polarity bit of 0 passes the result unchanged.
- R7: `pin_oe[n]` equals control term n, and no other term affects it.
- R8: When a pin is not enabled, the product terms see that pin's `pin_in` value.
- R9: When a pin is enabled, the product terms see that pin's own `pin_out` value, and `pin_in` for that pin is ignored.
- R10: While `cfg_load` is 1, `pin_oe` and `pin_out` are both 0.
- R11: While `cfg_load` is 0, the configuration is held and `cfg_din` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset; restores all links connected and polarity active-high |
| cfg_load | input | 1 | Shift enable for the configuration register; forces the pins off while high |
| cfg_din | input | 1 | Serial configuration bit |
| in_i | input | N_IN | Dedicated logic inputs |
| pin_in | input | N_IO | Value sampled from each bidirectional pin |
| pin_out | output | N_IO | Value the array drives on each pin |
| pin_oe | output | N_IO | Output enable of each pin |

## Verification
The hardest case to reach from the ports is feedback through an enabled pin. The array's own driven value has to re-enter a different term, with no term ever depending on itself. To get there, a directed configuration enables pin 0 with a term on a dedicated input. A term on variable pin 0 then drives a second enabled pin, while `pin_in` on pin 0 is driven to the opposite value. Next to that, a disabled pin is read by a term steering another enabled pin. Random configurations then either restrict all terms to dedicated inputs or switch every control term off, so that no loop can form. A behavioural model settles the feedback by iterating until the values are stable.

// File: rtl/pla_pkg.sv
package pla_pkg;

   localparam int unsigned LINKS_PER_VAR = 2;

   // bit index of one AND-plane link inside the AND section of the config
   function automatic int unsigned and_link_idx(input int unsigned term,
                                                input int unsigned var_i,
                                                input int unsigned n_var,
                                                input bit          inverted);
      return term * LINKS_PER_VAR * n_var + var_i * LINKS_PER_VAR + (inverted ? 1 : 0);
   endfunction

   // bit index of one OR-plane link inside the OR section of the config
   function automatic int unsigned or_link_idx(input int unsigned term,
                                               input int unsigned out_i,
                                               input int unsigned n_out);
      return term * n_out + out_i;
   endfunction

endpackage

// File: rtl/pla_cfg_shift.sv
module pla_cfg_shift #(
   parameter int unsigned AND_BITS = 1848,
   parameter int unsigned OR_BITS  = 320,
   parameter int unsigned POL_BITS = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                load,
   input  logic                din,
   output logic [AND_BITS-1:0] and_links,
   output logic [OR_BITS-1:0]  or_links,
   output logic [POL_BITS-1:0] pol
);

   localparam int unsigned TOT = AND_BITS + OR_BITS + POL_BITS;
   localparam logic [TOT-1:0] RST_VAL = {{POL_BITS{1'b0}}, {(AND_BITS + OR_BITS){1'b1}}};

   logic [TOT-1:0] cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= RST_VAL;
      end else if (load) begin
         cfg_q <= {din, cfg_q[TOT-1:1]};
      end
   end

   assign and_links = cfg_q[AND_BITS-1:0];
   assign or_links  = cfg_q[AND_BITS+OR_BITS-1:AND_BITS];
   assign pol       = cfg_q[TOT-1:AND_BITS+OR_BITS];

   // R11: configuration frozen whenever shifting is off
   p_cfg_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(cfg_q));

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane import pla_pkg::*; #(
   parameter int unsigned N_VAR  = 22,
   parameter int unsigned N_TERM = 42
) (
   input  logic                                    clk,
   input  logic                                    rst_n,
   input  logic [N_TERM*LINKS_PER_VAR*N_VAR-1:0]   links,
   input  logic [N_VAR-1:0]                        vars,
   output logic [N_TERM-1:0]                       terms
);

   for (genvar t = 0; t < N_TERM; t++) begin : g_term
      logic [N_VAR-1:0] lk_true;
      logic [N_VAR-1:0] lk_inv;

      for (genvar v = 0; v < N_VAR; v++) begin : g_var
         assign lk_true[v] = links[and_link_idx(t, v, N_VAR, 1'b0)];
         assign lk_inv[v]  = links[and_link_idx(t, v, N_VAR, 1'b1)];
      end

      // a connected true link demands 1, a connected inverted link demands 0
      assign terms[t] = &((~lk_true | vars) & (~lk_inv | ~vars));

      // R3: a variable with both links kept kills the term
      p_conflict_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
         ((lk_true & lk_inv) != '0) |-> !terms[t]);

      // R4: a term with every link cut is always true
      p_all_cut_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
         ((lk_true | lk_inv) == '0) |-> terms[t]);
   end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane import pla_pkg::*; #(
   parameter int unsigned N_LT   = 32,
   parameter int unsigned N_IO   = 10,
   parameter bit          POL_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N_LT-1:0]       lt,
   input  logic [N_LT*N_IO-1:0]  or_links,
   input  logic [N_IO-1:0]       pol,
   output logic [N_IO-1:0]       sum_o
);

   for (genvar o = 0; o < N_IO; o++) begin : g_out
      logic [N_LT-1:0] col;
      logic            hit;

      for (genvar t = 0; t < N_LT; t++) begin : g_col
         assign col[t] = or_links[or_link_idx(t, o, N_IO)];
      end

      assign hit = |(lt & col);

      if (POL_EN) begin : g_pol
         assign sum_o[o] = hit ^ pol[o];

         // R5 R6: an output with no connected term shows only its polarity
         p_or_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (col == '0) |-> (sum_o[o] == pol[o]));

         // R6: an active-high output with a live connected term is 1
         p_pol_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (((lt & col) != '0) && !pol[o]) |-> sum_o[o]);
      end else begin : g_nopol
         assign sum_o[o] = hit;

         p_or_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (col == '0) |-> !sum_o[o]);
      end
   end

endmodule

// File: rtl/pla_array.sv
module pla_array import pla_pkg::*; #(
   parameter int unsigned N_IN   = 12,
   parameter int unsigned N_IO   = 10,
   parameter int unsigned N_LT   = 32,
   parameter bit          POL_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_load,
   input  logic            cfg_din,
   input  logic [N_IN-1:0] in_i,
   input  logic [N_IO-1:0] pin_in,
   output logic [N_IO-1:0] pin_out,
   output logic [N_IO-1:0] pin_oe
);

   localparam int unsigned N_VAR    = N_IN + N_IO;
   localparam int unsigned N_TERM   = N_LT + N_IO;
   localparam int unsigned AND_BITS = N_TERM * LINKS_PER_VAR * N_VAR;
   localparam int unsigned OR_BITS  = N_LT * N_IO;
   localparam int unsigned CFG_BITS = AND_BITS + OR_BITS + N_IO;

   if (N_IN < 1 || N_IO < 1 || N_LT < 1) begin : g_bad_size
      $error("pla_array: every size parameter must be at least 1");
   end
   if (CFG_BITS > 65536) begin : g_bad_cfg
      $error("pla_array: configuration register too long");
   end

   logic [AND_BITS-1:0] and_links;
   logic [OR_BITS-1:0]  or_links;
   logic [N_IO-1:0]     pol;
   logic [N_IO-1:0]     fb;
   logic [N_VAR-1:0]    vars;
   logic [N_TERM-1:0]   terms;
   logic [N_IO-1:0]     sums;

   pla_cfg_shift #(
      .AND_BITS (AND_BITS),
      .OR_BITS  (OR_BITS),
      .POL_BITS (N_IO)
   ) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cfg_load),
      .din       (cfg_din),
      .and_links (and_links),
      .or_links  (or_links),
      .pol       (pol)
   );

   // enabled pins return their own driven value, the rest sample the outside
   assign fb   = (pin_oe & pin_out) | (~pin_oe & pin_in);
   assign vars = {fb, in_i};

   pla_and_plane #(
      .N_VAR  (N_VAR),
      .N_TERM (N_TERM)
   ) u_and (
      .clk   (clk),
      .rst_n (rst_n),
      .links (and_links),
      .vars  (vars),
      .terms (terms)
   );

   pla_or_plane #(
      .N_LT   (N_LT),
      .N_IO   (N_IO),
      .POL_EN (POL_EN)
   ) u_or (
      .clk      (clk),
      .rst_n    (rst_n),
      .lt       (terms[N_LT-1:0]),
      .or_links (or_links),
      .pol      (pol),
      .sum_o    (sums)
   );

   assign pin_oe  = cfg_load ? '0 : terms[N_TERM-1:N_LT];
   assign pin_out = cfg_load ? '0 : sums;

   // R9: an enabled pin is read back as the value the array drives on it
   for (genvar n = 0; n < N_IO; n++) begin : g_fb_chk
      p_fb_own_r9: assert property (@(posedge clk) disable iff (!rst_n)
         pin_oe[n] |-> (vars[N_IN+n] == pin_out[n]));
   end

endmodule

// File: tb/pla_array_tb.sv
module pla_array_tb_top;

   localparam int N_IN     = 12;
   localparam int N_IO     = 10;
   localparam int N_LT     = 32;
   localparam int N_VAR    = N_IN + N_IO;
   localparam int N_TERM   = N_LT + N_IO;
   localparam int AND_BITS = N_TERM * 2 * N_VAR;
   localparam int OR_BITS  = N_LT * N_IO;
   localparam int TOT      = AND_BITS + OR_BITS + N_IO;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic            rst_n;
   logic            cfg_load;
   logic            cfg_din;
   logic [N_IN-1:0] in_i;
   logic [N_IO-1:0] pin_in;
   logic [N_IO-1:0] pin_out;
   logic [N_IO-1:0] pin_oe;

   pla_array dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_load (cfg_load),
      .cfg_din  (cfg_din),
      .in_i     (in_i),
      .pin_in   (pin_in),
      .pin_out  (pin_out),
      .pin_oe   (pin_oe)
   );

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   // intended configuration, held as plain arrays
   bit m_tl [N_TERM][N_VAR];
   bit m_cl [N_TERM][N_VAR];
   bit m_or [N_LT][N_IO];
   bit m_pol[N_IO];

   task automatic cfg_virgin();
      for (int t = 0; t < N_TERM; t++)
         for (int v = 0; v < N_VAR; v++) begin m_tl[t][v] = 1; m_cl[t][v] = 1; end
      for (int t = 0; t < N_LT; t++)
         for (int o = 0; o < N_IO; o++) m_or[t][o] = 1;
      for (int o = 0; o < N_IO; o++) m_pol[o] = 0;
   endtask

   task automatic cfg_start();
      cfg_virgin();
      for (int t = 0; t < N_LT; t++)
         for (int o = 0; o < N_IO; o++) m_or[t][o] = 0;
   endtask

   task automatic cut_term(input int t);
      for (int v = 0; v < N_VAR; v++) begin m_tl[t][v] = 0; m_cl[t][v] = 0; end
   endtask

   function automatic bit cfg_bit_at(input int idx);
      int k;
      if (idx < AND_BITS) begin
         k = idx % (2 * N_VAR);
         return (k % 2) ? m_cl[idx / (2 * N_VAR)][k / 2] : m_tl[idx / (2 * N_VAR)][k / 2];
      end else if (idx < AND_BITS + OR_BITS) begin
         k = idx - AND_BITS;
         return m_or[k / N_IO][k % N_IO];
      end
      return m_pol[idx - AND_BITS - OR_BITS];
   endfunction

   // behavioural evaluation; feedback settled by repeated passes
   task automatic model(input logic [N_IN-1:0] iv, input logic [N_IO-1:0] pv,
                        output logic [N_IO-1:0] eo, output logic [N_IO-1:0] ee);
      bit [N_IO-1:0]   po = '0;
      bit [N_IO-1:0]   pe = '0;
      bit [N_TERM-1:0] tv;
      for (int it = 0; it < 8; it++) begin
         for (int t = 0; t < N_TERM; t++) begin
            bit val = 1;
            for (int v = 0; v < N_VAR; v++) begin
               bit x;
               if (v < N_IN) x = iv[v];
               else x = pe[v-N_IN] ? po[v-N_IN] : pv[v-N_IN];
               if (m_tl[t][v] && !x) val = 0;
               if (m_cl[t][v] && x) val = 0;
            end
            tv[t] = val;
         end
         for (int o = 0; o < N_IO; o++) begin
            bit s = 0;
            for (int t = 0; t < N_LT; t++) if (m_or[t][o] && tv[t]) s = 1;
            po[o] = s ^ m_pol[o];
            pe[o] = tv[N_LT+o];
         end
      end
      eo = po;
      ee = pe;
   endtask

   task automatic check_val(input string tag, input string what,
                            input logic [N_IO-1:0] act, input logic [N_IO-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic compare(input string tag);
      logic [N_IO-1:0] eo, ee;
      model(in_i, pin_in, eo, ee);
      check_val(tag, "pin_out", pin_out, eo);
      check_val(tag, "pin_oe", pin_oe, ee);
   endtask

   task automatic apply(input logic [N_IN-1:0] iv, input logic [N_IO-1:0] pv, input string tag);
      @(negedge clk);
      in_i    = iv;
      pin_in  = pv;
      cfg_din = 1'($urandom);   // R11: toggling data while not loading
      #1 compare(tag);
   endtask

   task automatic load_cfg();
      for (int i = 0; i < TOT; i++) begin
         @(negedge clk);
         cfg_load = 1'b1;
         cfg_din  = cfg_bit_at(i);
         if (i == TOT / 2 || i == TOT - 1) begin
            in_i   = N_IN'($urandom);
            pin_in = N_IO'($urandom);
            #1;
            check_val("R10", "pin_out", pin_out, '0);
            check_val("R10", "pin_oe", pin_oe, '0);
         end
      end
      @(negedge clk);
      cfg_load = 1'b0;
   endtask

   task automatic rand_cfg(input bit use_pins);
      for (int t = 0; t < N_TERM; t++) begin
         for (int v = 0; v < N_VAR; v++) begin
            int r = $urandom % 16;
            m_tl[t][v] = 0;
            m_cl[t][v] = 0;
            if (v >= N_IN && !use_pins) continue;
            if (r == 15) begin m_tl[t][v] = 1; m_cl[t][v] = 1; end
            else if (r >= 13) m_tl[t][v] = 1;
            else if (r >= 11) m_cl[t][v] = 1;
         end
         if (use_pins && t >= N_LT) begin m_tl[t][0] = 1; m_cl[t][0] = 1; end
      end
      for (int t = 0; t < N_LT; t++)
         for (int o = 0; o < N_IO; o++) m_or[t][o] = (($urandom % 4) == 0);
      for (int o = 0; o < N_IO; o++) m_pol[o] = 1'($urandom);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      rst_n    = 1'b0;
      cfg_load = 1'b0;
      cfg_din  = 1'b0;
      in_i     = '0;
      pin_in   = '0;
      cfg_virgin();
      repeat (2) @(negedge clk);
      in_i   = N_IN'($urandom);
      pin_in = N_IO'($urandom);
      #1;
      check_val("R1", "pin_out", pin_out, '0);
      check_val("R1", "pin_oe", pin_oe, '0);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < 10; k++) apply(N_IN'($urandom), N_IO'($urandom), "R1");

      // directed logic configuration
      cfg_start();
      cut_term(0); m_tl[0][0] = 1;
      cut_term(1); m_cl[1][1] = 1;
      cut_term(2);
      cut_term(3); m_tl[3][2] = 1; m_cl[3][2] = 1;
      m_or[0][0] = 1; m_or[1][1] = 1; m_or[0][2] = 1; m_or[1][2] = 1;
      m_or[3][3] = 1; m_or[2][4] = 1; m_pol[4] = 1;
      m_or[0][5] = 1; m_pol[5] = 1; m_pol[7] = 1;
      cut_term(N_LT + 0); cut_term(N_LT + 2);
      load_cfg();
      apply('0, '0, "R2 R3 R4 R5 R6 R7");
      check_val("R2 R3 R5 R6", "pin_out hand", pin_out, 10'h0A6);
      check_val("R7", "pin_oe hand", pin_oe, 10'h005);
      for (int p = 0; p < 16; p++) begin
         logic [N_IN-1:0] iv = N_IN'($urandom);
         iv[3:0] = p[3:0];
         apply(iv, N_IO'($urandom), "R3 R4 R5 R6 R11");
      end

      // directed feedback configuration
      cfg_start();
      cut_term(0); m_tl[0][0] = 1; m_or[0][0] = 1; cut_term(N_LT + 0);
      cut_term(4); m_tl[4][N_IN+0] = 1; m_tl[4][1] = 1; m_or[4][1] = 1; cut_term(N_LT + 1);
      cut_term(5); m_tl[5][N_IN+2] = 1; m_or[5][3] = 1; cut_term(N_LT + 3);
      load_cfg();
      apply(12'h003, 10'h000, "R9");
      check_val("R9", "pin_out[1] own feedback", {9'd0, pin_out[1]}, 10'd1);
      apply(12'h002, 10'h001, "R9");
      check_val("R9", "pin_out[1] ignores pin_in", {9'd0, pin_out[1]}, 10'd0);
      apply(12'h000, 10'h004, "R8");
      check_val("R8", "pin_out[3] from pin_in", {9'd0, pin_out[3]}, 10'd1);
      apply(12'h000, 10'h000, "R8");
      check_val("R8", "pin_out[3] from pin_in", {9'd0, pin_out[3]}, 10'd0);
      for (int k = 0; k < 40; k++) apply(N_IN'($urandom), N_IO'($urandom), "R8 R9");

      // random loop-free configurations
      for (int c = 0; c < 8; c++) begin
         rand_cfg(1'b0);
         load_cfg();
         for (int k = 0; k < 60; k++) apply(N_IN'($urandom), N_IO'($urandom), "R5 R6 R7 R11");
      end
      for (int c = 0; c < 4; c++) begin
         rand_cfg(1'b1);
         load_cfg();
         for (int k = 0; k < 60; k++) apply(N_IN'($urandom), N_IO'($urandom), "R3 R4 R8");
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule